// File: doc/BRIEF.md
# Packed 4:2:2 Pixel Unpacker

This block sits behind the fetch path of a display layer that reads a packed 4:2:2 frame buffer. Every 32-bit input word carries two horizontally adjacent pixels. The two pixels have their own luma samples and share one pair of chroma samples. The block splits each word into two output beats, one pixel per beat, each a (Y, U, V) byte triple. A control word chooses the enable, the buffer format and a 2-bit byte-sequence code. The sequence code reads the bytes from the most significant byte of the word down to the least significant byte. A byte order that software names from the lowest address upward therefore selects the mirrored code.

Both sides use valid/ready handshakes. The output triple stays frozen while the consumer stalls. A new word is taken only when the held word has no pixel left to send, or when its last pixel leaves in that same cycle. The block adds 32 to a running bit count for each word it accepts. It compares that count with a programmed line width given in bits (the byte pitch times 8). It flags the last pixel of the word that brings the count up to the line width, and then starts the next line from zero.

Top module: `yuv422_unpack`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: The control word enables the block when bit 0 is 1 and bits 14:12 equal 3 (packed 4:2:2). Bits 9:8 hold the sequence code. With code 0, Y0 is byte 0, Y1 is byte 2, U is byte 3 and V is byte 1. Byte 0 is bits 7:0, the lowest address.
- R3: With code 1, Y0 is byte 1, Y1 is byte 3, U is byte 2 and V is byte 0.
- R4: With code 2, Y0 is byte 0, Y1 is byte 2, U is byte 1 and V is byte 3. This is the lowest-address-first order Y0 U Y1 V.
- R5: With code 3, Y0 is byte 1, Y1 is byte 3, U is byte 0 and V is byte 2.
- R6: Each accepted word gives exactly two output pixels, in this order: (Y0,U,V) and then (Y1,U,V).
- R7: While out_valid is 1 and out_ready is 0, the outputs hold their values and out_valid stays 1 in the next cycle.
- R8: in_ready is 0 while a pixel is held that is not leaving in that cycle as the second pixel of its word.
- R9: A word accepted while bit 0 of the control word is 0 is dropped. It produces no output pixel and does not add to the bit count.
- R10: A word accepted while bits 14:12 differ from 3 is dropped in the same way.
- R11: out_eol is 1 only on the second pixel of a word whose acceptance makes the running count (32 per word) reach or pass line_bits. The count then restarts from 0.
- R12: The sequence code is captured with each word. Changing the control word while that word's pixels are held does not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl | input | 32 | Control word: enable bit 0, sequence code bits 9:8, format bits 14:12 |
| line_bits | input | LW_W | Line width in bits |
| in_data | input | 32 | Packed word, byte 0 = lowest address |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take a word |
| out_y | output | 8 | Luma of the current pixel |
| out_u | output | 8 | Shared U chroma |
| out_v | output | 8 | Shared V chroma |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_eol | output | 1 | Last pixel of a line |

## Verification
The bench uses a distinct byte value in each position of a word, so any swap of luma and chroma bytes, or an unmirrored sequence code, shows up as a wrong triple in the scoreboard. Random output stalls check that frozen outputs do not tear or advance and that no word is taken while the first pixel is still held. A design that accepted early would lose the second pixel. Words sent while the block is disabled or set to a different format must leave nothing in the queue. The line width is tested both as an exact multiple of 32 and as a value that is not a multiple. A counter that does not restart, or that counts dropped words, would move the end-of-line flag.

// File: rtl/yuv422_unpack.sv
module yuv422_unpack #(
  parameter int LW_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     ctrl,
  input  logic [LW_W-1:0] line_bits,
  input  logic [31:0]     in_data,
  input  logic            in_valid,
  output logic            in_ready,
  output logic [7:0]      out_y,
  output logic [7:0]      out_u,
  output logic [7:0]      out_v,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_eol
);
  localparam int          WORD_BITS = 32;
  localparam logic [2:0]  FMT_P422  = 3'd3;

  logic            full, phase, last;
  logic [31:0]     word;
  logic [1:0]      seq;
  logic [LW_W-1:0] cnt;
  logic [LW_W:0]   sum;
  logic            active, take, step, drain;
  logic [7:0]      y0, y1, u, v;

  assign active   = ctrl[0] && (ctrl[14:12] == FMT_P422);
  assign step     = out_valid && out_ready;
  assign drain    = step && phase;
  assign in_ready = !full || drain;
  assign take     = in_valid && in_ready;
  assign sum      = {1'b0, cnt} + (LW_W+1)'(WORD_BITS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full  <= 1'b0;
      phase <= 1'b0;
      last  <= 1'b0;
      word  <= '0;
      seq   <= '0;
      cnt   <= '0;
    end else begin
      if (step) begin
        if (phase) full <= 1'b0;
        phase <= ~phase;
      end
      if (take && active) begin
        full  <= 1'b1;
        phase <= 1'b0;
        word  <= in_data;
        seq   <= ctrl[9:8];
        if (sum >= {1'b0, line_bits}) begin
          last <= 1'b1;
          cnt  <= '0;
        end else begin
          last <= 1'b0;
          cnt  <= sum[LW_W-1:0];
        end
      end
    end
  end

  always_comb begin
    case (seq)
      2'd0:    begin y0 = word[7:0];   y1 = word[23:16]; u = word[31:24]; v = word[15:8];  end
      2'd1:    begin y0 = word[15:8];  y1 = word[31:24]; u = word[23:16]; v = word[7:0];   end
      2'd2:    begin y0 = word[7:0];   y1 = word[23:16]; u = word[15:8];  v = word[31:24]; end
      default: begin y0 = word[15:8];  y1 = word[31:24]; u = word[7:0];   v = word[23:16]; end
    endcase
  end

  assign out_valid = full;
  assign out_y     = phase ? y1 : y0;
  assign out_u     = u;
  assign out_v     = v;
  assign out_eol   = full && phase && last;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y) && $stable(out_u) && $stable(out_v) && $stable(out_eol))) // R7
    else $error("stall hold");
  AST_NO_EARLY_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && phase)) |-> !in_ready) // R8
    else $error("early take");
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !(in_valid && active)) |=> !out_valid) // R9
    else $error("output while off");
  AST_EOL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> (out_valid && phase)) // R11
    else $error("eol on first pixel");
  AST_TWO_BEATS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !phase) |=> (out_valid && phase)) // R6
    else $error("second pixel missing");
endmodule

// File: tb/yuv422_unpack_bench.sv
module yuv422_unpack_bench;
  localparam int LW_W = 16;

  logic            clk = 0, rst_n = 0;
  logic [31:0]     ctrl = 0, in_data = 0;
  logic [LW_W-1:0] line_bits = 96;
  logic            in_valid = 0, in_ready, out_valid, out_ready = 1, out_eol;
  logic [7:0]      out_y, out_u, out_v;

  yuv422_unpack #(.LW_W(LW_W)) u_yuv422_unpack (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .line_bits(line_bits),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_y(out_y), .out_u(out_u), .out_v(out_v), .out_valid(out_valid),
    .out_ready(out_ready), .out_eol(out_eol));

  always #5 clk = ~clk;

  int total = 0, bad = 0, mcnt = 0, rdy_mode = 0;
  logic [24:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] lfsr = 16'hACE1;
  int          bcnt = 0;
  logic        done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  function automatic logic [31:0] cfg(input int code);
    return 32'h3001 | (code << 8);
  endfunction

  task automatic send(input logic [31:0] w, input logic [31:0] c, input string tag);
    logic [7:0] b[4];
    logic [7:0] ya, yb, uu, vv;
    bit ok, en, eol;
    for (int i = 0; i < 4; i++) b[i] = w[8*i +: 8];
    en = c[0] && (c[14:12] == 3);
    case (c[9:8])
      0: begin ya = b[0]; yb = b[2]; uu = b[3]; vv = b[1]; end
      1: begin ya = b[1]; yb = b[3]; uu = b[2]; vv = b[0]; end
      2: begin ya = b[0]; yb = b[2]; uu = b[1]; vv = b[3]; end
      default: begin ya = b[1]; yb = b[3]; uu = b[0]; vv = b[2]; end
    endcase
    @(negedge clk);
    in_valid = 1; in_data = w; ctrl = c;
    forever begin
      #1 ok = in_ready;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    if (en) begin
      bcnt += 32; eol = (bcnt >= line_bits);
      if (eol) bcnt = 0;
      exp_q.push_back({1'b0, ya, uu, vv}); tag_q.push_back(tag);
      exp_q.push_back({eol, yb, uu, vv}); tag_q.push_back(tag);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain_wait();
    int n = 0;
    while ((exp_q.size() != 0 || out_valid) && n < 2000) begin @(negedge clk); n++; end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
  end

  logic        prev_stall = 0;
  logic [24:0] prev_val;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall)  // R7
        chk(out_valid && {out_eol, out_y, out_u, out_v} == prev_val, "R7 hold",
            {out_valid, out_eol, out_y, out_u, out_v}, {1'b1, prev_val});
      if (out_valid && !out_ready)  // R8
        chk(!in_ready, "R8 in_ready low while held", in_ready, 0);
      prev_stall = out_valid && !out_ready;
      prev_val = {out_eol, out_y, out_u, out_v};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk(0, "R9/R10 unexpected pixel", {out_eol, out_y, out_u, out_v}, 0);
        else begin
          logic [24:0] e; string t;
          e = exp_q.pop_front(); t = tag_q.pop_front();
          chk({out_eol, out_y, out_u, out_v} == e, {t, " R6 R11 pixel"}, {out_eol, out_y, out_u, out_v}, e);
          mcnt++;
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++; $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad); $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    chk(!out_valid && in_ready, "R1 reset", {out_valid, in_ready}, 2'b01);
    rst_n = 1;
    ctrl = cfg(0);
    send(32'h44332211, cfg(0), "R2");
    send(32'h88776655, cfg(0), "R2");
    send(32'hCCBBAA99, cfg(0), "R2");
    drain_wait();
    rdy_mode = 1;
    send(32'h14131211, cfg(1), "R3");
    send(32'h24232221, cfg(1), "R3");
    send(32'h34333231, cfg(2), "R4");
    send(32'h44434241, cfg(2), "R4");
    send(32'h54535251, cfg(3), "R5");
    send(32'h64636261, cfg(3), "R5");
    drain_wait();
    chk(exp_q.size() == 0, "R6 all pixels out", exp_q.size(), 0);
    rdy_mode = 0;
    mcnt = 0;
    send(32'hDEADBEEF, 32'h3000, "R9");
    send(32'h01020304, 32'h3100, "R9");
    seen = 0;
    repeat (10) begin @(negedge clk); #3 if (out_valid) seen++; end
    chk(seen == 0 && mcnt == 0, "R9 disabled drops", seen, 0);
    send(32'hFACEB00C, 32'h4001, "R10");
    send(32'h0BADF00D, 32'h1201, "R10");
    seen = 0;
    repeat (10) begin @(negedge clk); #3 if (out_valid) seen++; end
    chk(seen == 0 && mcnt == 0, "R10 other format drops", seen, 0);
    line_bits = 40;
    for (int i = 0; i < 4; i++) send(32'h70605040 + i, cfg(i), "R11");
    drain_wait();
    chk(mcnt == 8, "R11 pixel count", mcnt, 8);
    line_bits = 96;
    rdy_mode = 2;
    send(32'hA4A3A2A1, cfg(2), "R12");
    @(negedge clk); ctrl = cfg(1);
    repeat (3) @(negedge clk);
    rdy_mode = 1;
    drain_wait();
    send(32'hB4B3B2B1, cfg(0), "R12");
    drain_wait();
    chk(exp_q.size() == 0, "R12 queue empty", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule